// File: doc/BRIEF.md
# Five-State Cache Line Coherence Controller

This block tracks the coherence state of every line in a small, direct-indexed write-back cache that sits on a shared snooping bus. Each line is in one of five states: Invalid, Shared, Exclusive, Recent or Modified. Exclusive and Recent both mark the only clean valid copy of a line anywhere in the system. A local write to an Exclusive line turns it Modified with no bus traffic. A local write to a Recent line must first win an upgrade transaction on the bus before the line can become Modified.

The processor side presents read, write and evict requests. Requests that hit in a suitable state complete at the next clock edge. Other requests raise a bus request that stays up until the bus reports completion, and that completion carries the shared and dirty responses collected from the other caches. When another cache's transaction is snooped, the block answers in the same cycle with shared, supply-data and dirty flags, and it updates the line at the next edge. A dirty line that is taken away or evicted raises a one-cycle writeback pulse. Data storage, replacement and bus arbitration are outside this block.

Top module: `coh_line_ctrl`

## Requirements
- R1: Line states are encoded as Invalid=0, Shared=1, Exclusive=2, Recent=3, Modified=4. Reset puts every line in Invalid. `rd_state` combinationally shows the state of line `rd_idx`.
- R2: A local read (op 0) of a valid line completes with no bus request and no state change. A local read of an Invalid line raises `bus_req_valid` with op 1 (read) in the cycle after acceptance.
- R3: A local write (op 1) to an Exclusive line makes it Modified at the accepting edge with no bus request. A write to a Modified line leaves it Modified with no bus request.
- R4: A local write to a Recent or Shared line raises a bus request with op 3 (upgrade). The line keeps its state until `bus_done`, and then becomes Modified.
- R5: A local write to an Invalid line raises a bus request with op 2 (read-for-ownership). After `bus_done` the line is Modified.
- R6: When a read completes on the bus, the line fills as Recent if `bus_dirty_in` is set, otherwise as Shared if `bus_shared_in` is set, otherwise as Exclusive.
- R7: For a snooped read (snoop op 1), any valid line asserts `snp_shared` and `snp_supply` in the same cycle, and only a Modified line also asserts `snp_dirty`. At the next edge, Modified becomes Invalid with a writeback, Exclusive and Recent become Shared, and Shared and Invalid are unchanged.
- R8: A snooped read-for-ownership (op 2) or invalidate (op 3) makes the line Invalid. For op 2 a valid line asserts `snp_supply`. A Modified line asserts `snp_dirty` and raises a writeback.
- R9: Evicting (op 2) a Modified line makes it Invalid and raises a writeback. Evicting a clean line makes it Invalid with no writeback.
- R10: `wb_valid` is high for exactly the one cycle after the edge that took a Modified line away, and `wb_idx` names that line.
- R11: `lreq_ready` is low while a bus request is outstanding and in any cycle with `snp_valid` high. A request presented while `lreq_ready` is low is ignored.
- R12: The outstanding bus op follows the line's current state. If a pending upgrade's line is invalidated by a snoop, the op becomes read-for-ownership.
- R13: Across caches sharing the bus, a line held Modified, Exclusive or Recent in one cache is Invalid in every other cache, and Shared coexists only with Shared or Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_op | input | 2 | Local op: 0 read, 1 write, 2 evict, 3 none |
| lreq_idx | input | IDX_W | Line index of the local request |
| lreq_ready | output | 1 | Local request can be accepted this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | Bus op: 1 read, 2 read-for-ownership, 3 upgrade |
| bus_req_idx | output | IDX_W | Line index of the bus request |
| bus_done | input | 1 | Own bus transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache reported a copy |
| bus_dirty_in | input | 1 | Another cache supplied dirty data |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped op: 1 read, 2 read-for-ownership, 3 invalidate |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache supplies the data |
| snp_dirty | output | 1 | The supplied data is dirty |
| wb_valid | output | 1 | Writeback request pulse |
| wb_idx | output | IDX_W | Line to write back |
| rd_idx | input | IDX_W | State observation index |
| rd_state | output | 3 | State of line `rd_idx` |

## Verification
The snoop flags and `rd_state` are combinational, so the bench reads them shortly after driving inputs in the low half of the clock. Line state changes, the writeback pulse and a new bus request become visible after the first rising edge that sees the stimulus. The bench therefore holds every request across exactly one rising edge and samples at the falling edge that follows. Three instances share a modelled bus. After each step the bench compares every line of every cache with its expected state and checks every pair of caches for compatible states.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_R = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        LOP_READ  = 2'd0,
        LOP_WRITE = 2'd1,
        LOP_EVICT = 2'd2,
        LOP_NONE  = 2'd3
    } lop_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_READ = 2'd1,
        BOP_RFO  = 2'd2,
        BOP_UPG  = 2'd3
    } bop_e;

    typedef struct packed {
        line_st_e nxt;
        logic     need_bus;
        logic     is_write;
        logic     wb;
    } local_dec_t;

    typedef struct packed {
        line_st_e nxt;
        logic     shared;
        logic     supply;
        logic     dirty;
    } snoop_dec_t;

endpackage

// File: rtl/coh_local_decide.sv
module coh_local_decide
    import coh_pkg::*;
(
    input  line_st_e   cur,
    input  lop_e       op,
    output local_dec_t dec
);
    always_comb begin
        dec          = '0;
        dec.nxt      = cur;
        unique case (op)
            LOP_READ: begin
                if (cur == ST_I) dec.need_bus = 1'b1;
            end
            LOP_WRITE: begin
                if (cur == ST_M || cur == ST_E) begin
                    dec.nxt = ST_M;
                end else begin
                    dec.need_bus = 1'b1;
                    dec.is_write = 1'b1;
                end
            end
            LOP_EVICT: begin
                dec.nxt = ST_I;
                dec.wb  = (cur == ST_M);
            end
            default: ;
        endcase
    end

    always_comb begin
        if (dec.need_bus) assert (dec.wb == 1'b0);
    end
endmodule

// File: rtl/coh_snoop_decide.sv
module coh_snoop_decide
    import coh_pkg::*;
(
    input  logic       valid,
    input  line_st_e   cur,
    input  bop_e       op,
    output snoop_dec_t dec
);
    logic held;
    assign held = (cur != ST_I);

    always_comb begin
        dec     = '0;
        dec.nxt = cur;
        if (valid) begin
            unique case (op)
                BOP_READ: begin
                    dec.shared = held;
                    dec.supply = held;
                    dec.dirty  = (cur == ST_M);
                    if (cur == ST_M)                    dec.nxt = ST_I;
                    else if (cur == ST_E || cur == ST_R) dec.nxt = ST_S;
                end
                BOP_RFO: begin
                    dec.shared = held;
                    dec.supply = held;
                    dec.dirty  = (cur == ST_M);
                    dec.nxt    = ST_I;
                end
                BOP_UPG: begin
                    dec.shared = held;
                    dec.dirty  = (cur == ST_M);
                    dec.nxt    = ST_I;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (dec.dirty) assert (dec.nxt == ST_I);
    end
endmodule

// File: rtl/coh_bus_select.sv
module coh_bus_select
    import coh_pkg::*;
(
    input  line_st_e cur,
    input  logic     pend_wr,
    input  logic     shared_in,
    input  logic     dirty_in,
    output bop_e     op,
    output line_st_e fill
);
    always_comb begin
        if (!pend_wr)          op = BOP_READ;
        else if (cur == ST_I)  op = BOP_RFO;
        else                   op = BOP_UPG;
    end

    always_comb begin
        if (pend_wr)        fill = ST_M;
        else if (dirty_in)  fill = ST_R;
        else if (shared_in) fill = ST_S;
        else                fill = ST_E;
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lreq_valid,
    input  logic [1:0]       lreq_op,
    input  logic [IDX_W-1:0] lreq_idx,
    output logic             lreq_ready,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_op,
    output logic [IDX_W-1:0] bus_req_idx,
    input  logic             bus_done,
    input  logic             bus_shared_in,
    input  logic             bus_dirty_in,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_shared,
    output logic             snp_supply,
    output logic             snp_dirty,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [2:0]       rd_state
);
    typedef struct packed {
        logic [NUM_LINES-1:0][2:0] lines;
        logic                      pend_v;
        logic                      pend_wr;
        logic [IDX_W-1:0]          pend_idx;
        logic                      wb_v;
        logic [IDX_W-1:0]          wb_idx;
    } regs_t;

    regs_t r_d, r_q;

    line_st_e   cur_l, cur_s, cur_p;
    local_dec_t ldec;
    snoop_dec_t sdec;
    bop_e       bop;
    line_st_e   fill;
    logic       accept;

    assign cur_l = line_st_e'(r_q.lines[lreq_idx]);
    assign cur_s = line_st_e'(r_q.lines[snp_idx]);
    assign cur_p = line_st_e'(r_q.lines[r_q.pend_idx]);

    coh_local_decide u_local (
        .cur (cur_l),
        .op  (lop_e'(lreq_op)),
        .dec (ldec)
    );

    coh_snoop_decide u_snoop (
        .valid (snp_valid),
        .cur   (cur_s),
        .op    (bop_e'(snp_op)),
        .dec   (sdec)
    );

    coh_bus_select u_bus (
        .cur       (cur_p),
        .pend_wr   (r_q.pend_wr),
        .shared_in (bus_shared_in),
        .dirty_in  (bus_dirty_in),
        .op        (bop),
        .fill      (fill)
    );

    // one state writer per cycle from the processor side: stall on any snoop
    assign lreq_ready = !r_q.pend_v && !snp_valid;
    assign accept     = lreq_valid && lreq_ready && (lop_e'(lreq_op) != LOP_NONE);

    always_comb begin
        r_d      = r_q;
        r_d.wb_v = 1'b0;

        if (snp_valid) begin
            r_d.lines[snp_idx] = sdec.nxt;
            if (sdec.dirty) begin
                r_d.wb_v   = 1'b1;
                r_d.wb_idx = snp_idx;
            end
        end

        if (accept) begin
            if (ldec.need_bus) begin
                r_d.pend_v   = 1'b1;
                r_d.pend_wr  = ldec.is_write;
                r_d.pend_idx = lreq_idx;
            end else begin
                r_d.lines[lreq_idx] = ldec.nxt;
            end
            if (ldec.wb) begin
                r_d.wb_v   = 1'b1;
                r_d.wb_idx = lreq_idx;
            end
        end

        if (r_q.pend_v && bus_done) begin
            r_d.lines[r_q.pend_idx] = fill;
            r_d.pend_v              = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_req_valid = r_q.pend_v;
    assign bus_req_op    = r_q.pend_v ? bop : BOP_NONE;
    assign bus_req_idx   = r_q.pend_idx;
    assign snp_shared    = sdec.shared;
    assign snp_supply    = sdec.supply;
    assign snp_dirty     = sdec.dirty;
    assign wb_valid      = r_q.wb_v;
    assign wb_idx        = r_q.wb_idx;
    assign rd_state      = r_q.lines[rd_idx];

    // R3: exclusive write turns modified with no bus activity
    p_silent_excl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lop_e'(lreq_op) == LOP_WRITE && cur_l == ST_E)
        |=> (!bus_req_valid && r_q.lines[$past(lreq_idx)] == ST_M));

    // R4: outstanding request is held, same line, until completion
    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_done) |=> (bus_req_valid && $stable(bus_req_idx)));

    // R5: an ownership transaction always ends in Modified
    p_own_done_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_done && bus_req_op != BOP_READ)
        |=> (r_q.lines[$past(bus_req_idx)] == ST_M));

    // R8: snooped ownership or invalidate leaves the line invalid
    p_snoop_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (bop_e'(snp_op) == BOP_RFO || bop_e'(snp_op) == BOP_UPG))
        |=> (r_q.lines[$past(snp_idx)] == ST_I));

    // R11: no local acceptance while a bus request is pending
    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !lreq_ready);

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line_chk
        // R1: only the five legal codes are ever held
        p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.lines[gi] <= 3'd4);
        // R10: a writeback names a line that was Modified one edge earlier
        p_wb_from_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid && wb_idx == IDX_W'(gi)) |-> ($past(r_q.lines[gi]) == ST_M));
    end
endmodule

// File: tb/coh_line_ctrl_test.sv
`timescale 1ns/1ps
module coh_line_ctrl_test;
    localparam int NC = 3;
    localparam int NL = 16;
    localparam int IW = 4;

    localparam int S_I = 0, S_S = 1, S_E = 2, S_R = 3, S_M = 4;
    localparam int O_RD = 0, O_WR = 1, O_EV = 2, O_NO = 3;
    localparam int B_RD = 1, B_RFO = 2, B_UPG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          lv   [NC];
    logic [1:0]    lop  [NC];
    logic [IW-1:0] lidx [NC];
    logic          lrdy [NC];
    logic          brv  [NC];
    logic [1:0]    bop  [NC];
    logic [IW-1:0] bidx [NC];
    logic          bdone[NC];
    logic          bsh  [NC];
    logic          bdr  [NC];
    logic          sv   [NC];
    logic [1:0]    sop  [NC];
    logic [IW-1:0] sidx [NC];
    logic          ssh  [NC];
    logic          ssup [NC];
    logic          sdr  [NC];
    logic          wbv  [NC];
    logic [IW-1:0] wbi  [NC];
    logic [IW-1:0] ridx [NC];
    logic [2:0]    rst_v[NC];

    int expst [NC][NL];
    int checks = 0;
    int errors = 0;

    for (genvar g = 0; g < NC; g++) begin : g_c
        coh_line_ctrl #(.NUM_LINES(NL)) uut (
            .clk(clk), .rst_n(rst_n),
            .lreq_valid(lv[g]), .lreq_op(lop[g]), .lreq_idx(lidx[g]), .lreq_ready(lrdy[g]),
            .bus_req_valid(brv[g]), .bus_req_op(bop[g]), .bus_req_idx(bidx[g]),
            .bus_done(bdone[g]), .bus_shared_in(bsh[g]), .bus_dirty_in(bdr[g]),
            .snp_valid(sv[g]), .snp_op(sop[g]), .snp_idx(sidx[g]),
            .snp_shared(ssh[g]), .snp_supply(ssup[g]), .snp_dirty(sdr[g]),
            .wb_valid(wbv[g]), .wb_idx(wbi[g]),
            .rd_idx(ridx[g]), .rd_state(rst_v[g])
        );
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // compares every line with the expectation and checks pairwise compatibility (R13)
    task automatic check_all(input string tag);
        for (int i = 0; i < NL; i++) begin
            for (int c = 0; c < NC; c++) ridx[c] = IW'(i);
            #0.1;
            for (int c = 0; c < NC; c++)
                check($sformatf("%s state c%0d line %0d", tag, c, i), int'(rst_v[c]), expst[c][i]);
            for (int a = 0; a < NC; a++) begin
                for (int b = a + 1; b < NC; b++) begin
                    int sa, sb;
                    bit ok;
                    sa = int'(rst_v[a]);
                    sb = int'(rst_v[b]);
                    ok = (sa == S_I) || (sb == S_I) || (sa == S_S && sb == S_S);
                    check($sformatf("R13 pair c%0d/c%0d line %0d (%0d,%0d)", a, b, i, sa, sb),
                          int'(ok), 1);
                end
            end
        end
    endtask

    task automatic do_local(input int c, input int op, input int idx, input bit exp_rdy,
                            input string tag);
        lv[c]   = 1'b1;
        lop[c]  = 2'(op);
        lidx[c] = IW'(idx);
        #0.5;
        check({tag, " ready"}, int'(lrdy[c]), int'(exp_rdy));
        @(posedge clk);
        @(negedge clk);
        lv[c]  = 1'b0;
        lop[c] = 2'(O_NO);
    endtask

    task automatic run_bus(input int c, input int exp_op, input bit e_sh, input bit e_sup,
                           input bit e_dr, input int wb_c, input string tag);
        int idx;
        bit sh, sup, dr;
        check({tag, " bus_req_valid"}, int'(brv[c]), 1);
        check({tag, " bus_req_op"}, int'(bop[c]), exp_op);
        idx = int'(bidx[c]);
        for (int o = 0; o < NC; o++) begin
            if (o != c) begin
                sv[o]   = 1'b1;
                sop[o]  = bop[c];
                sidx[o] = IW'(idx);
            end
        end
        #0.5;
        sh = 0; sup = 0; dr = 0;
        for (int o = 0; o < NC; o++) begin
            if (o != c) begin
                sh  |= ssh[o];
                sup |= ssup[o];
                dr  |= sdr[o];
            end
        end
        check({tag, " snoop shared"}, int'(sh), int'(e_sh));
        check({tag, " snoop supply"}, int'(sup), int'(e_sup));
        check({tag, " snoop dirty"}, int'(dr), int'(e_dr));
        bdone[c] = 1'b1;
        bsh[c]   = sh;
        bdr[c]   = dr;
        @(posedge clk);
        @(negedge clk);
        for (int o = 0; o < NC; o++) begin
            sv[o] = 1'b0; sop[o] = 2'd0; bdone[o] = 1'b0; bsh[o] = 1'b0; bdr[o] = 1'b0;
        end
        for (int o = 0; o < NC; o++)
            check($sformatf("R10 %s wb_valid c%0d", tag, o), int'(wbv[o]), int'(o == wb_c));
        if (wb_c >= 0) check({"R10 ", tag, " wb_idx"}, int'(wbi[wb_c]), idx);
        check({tag, " request cleared"}, int'(brv[c]), 0);
    endtask

    task automatic t_reset();
        for (int c = 0; c < NC; c++) begin
            check("R1 reset wb_valid", int'(wbv[c]), 0);
            check("R1 reset bus_req_valid", int'(brv[c]), 0);
            check("R11 reset ready", int'(lrdy[c]), 1);
        end
        check_all("R1 reset");
    endtask

    task automatic t_fill_paths();
        do_local(0, O_RD, 1, 1, "R2 miss c0");
        run_bus(0, B_RD, 0, 0, 0, -1, "R6 excl fill");
        expst[0][1] = S_E;
        check_all("R6 exclusive");
        do_local(1, O_RD, 1, 1, "R2 miss c1");
        run_bus(1, B_RD, 1, 1, 0, -1, "R7 clean supply");
        expst[0][1] = S_S; expst[1][1] = S_S;
        check_all("R7 shared fill");
    endtask

    task automatic t_upgrade_and_recent();
        do_local(0, O_WR, 1, 1, "R4 shared write");
        check_all("R4 before done");
        run_bus(0, B_UPG, 1, 0, 0, -1, "R4 upgrade");
        expst[0][1] = S_M; expst[1][1] = S_I;
        check_all("R4 after upgrade");
        do_local(2, O_RD, 1, 1, "R2 miss c2");
        run_bus(2, B_RD, 1, 1, 1, 0, "R7 dirty supply");
        expst[0][1] = S_I; expst[2][1] = S_R;
        check_all("R6 recent fill");
        do_local(2, O_WR, 1, 1, "R4 recent write");
        check("R4 recent waits", int'(brv[2]), 1);
        check_all("R4 recent held");
        run_bus(2, B_UPG, 0, 0, 0, -1, "R4 recent upgrade");
        expst[2][1] = S_M;
        check_all("R4 recent to modified");
    endtask

    task automatic t_hits();
        do_local(2, O_WR, 1, 1, "R3 modified write");
        check("R3 modified write no bus", int'(brv[2]), 0);
        do_local(2, O_RD, 1, 1, "R2 read hit");
        check("R2 read hit no bus", int'(brv[2]), 0);
        check_all("R2 hit unchanged");
        do_local(1, O_WR, 2, 1, "R5 invalid write");
        run_bus(1, B_RFO, 0, 0, 0, -1, "R5 rfo");
        expst[1][2] = S_M;
        do_local(0, O_RD, 3, 1, "R2 miss line3");
        run_bus(0, B_RD, 0, 0, 0, -1, "R6 line3");
        do_local(0, O_WR, 3, 1, "R3 exclusive write");
        check("R3 exclusive write no bus", int'(brv[0]), 0);
        expst[0][3] = S_M;
        check_all("R3 silent");
    endtask

    task automatic t_snoop_rfo_evict();
        do_local(1, O_WR, 3, 1, "R8 rfo on dirty");
        run_bus(1, B_RFO, 1, 1, 1, 0, "R8 rfo snoop");
        expst[0][3] = S_I; expst[1][3] = S_M;
        check_all("R8 after rfo");
        do_local(1, O_EV, 3, 1, "R9 evict dirty");
        check("R9 dirty evict wb_valid", int'(wbv[1]), 1);
        check("R9 dirty evict wb_idx", int'(wbi[1]), 3);
        do_local(1, O_EV, 2, 1, "R9 evict dirty 2");
        check("R9 dirty evict 2 wb_valid", int'(wbv[1]), 1);
        expst[1][3] = S_I; expst[1][2] = S_I;
        do_local(0, O_RD, 4, 1, "R2 miss line4");
        run_bus(0, B_RD, 0, 0, 0, -1, "R6 line4");
        do_local(0, O_EV, 4, 1, "R9 evict clean");
        check("R9 clean evict no wb", int'(wbv[0]), 0);
        check("R9 clean evict no bus", int'(brv[0]), 0);
        check_all("R9 evictions");
    endtask

    task automatic t_stall();
        do_local(0, O_RD, 5, 1, "R2 miss line5");
        check("R2 read op one cycle after accept", int'(bop[0]), B_RD);
        do_local(0, O_WR, 7, 0, "R11 busy");
        check("R11 busy request ignored idx", int'(bidx[0]), 5);
        check_all("R11 busy ignored");
        run_bus(0, B_RD, 0, 0, 0, -1, "R6 line5");
        expst[0][5] = S_E;
        sv[2] = 1'b1; sop[2] = 2'(B_RD); sidx[2] = IW'(9);
        do_local(2, O_WR, 9, 0, "R11 snoop stall");
        sv[2] = 1'b0; sop[2] = 2'd0;
        check("R11 snoop stall no bus", int'(brv[2]), 0);
        check_all("R11 snoop stall");
    endtask

    task automatic t_op_follows_state();
        do_local(0, O_RD, 6, 1, "R2 miss line6");
        run_bus(0, B_RD, 0, 0, 0, -1, "R6 line6");
        do_local(1, O_RD, 6, 1, "R2 miss line6 c1");
        run_bus(1, B_RD, 1, 1, 0, -1, "R7 line6 share");
        expst[0][6] = S_S; expst[1][6] = S_S;
        do_local(0, O_WR, 6, 1, "R12 c0 write");
        check("R12 c0 upgrade first", int'(bop[0]), B_UPG);
        do_local(1, O_WR, 6, 1, "R12 c1 write");
        run_bus(1, B_UPG, 1, 0, 0, -1, "R12 c1 wins");
        expst[0][6] = S_I; expst[1][6] = S_M;
        check_all("R12 after invalidation");
        check("R12 op now rfo", int'(bop[0]), B_RFO);
        run_bus(0, B_RFO, 1, 1, 1, 1, "R12 c0 rfo");
        expst[0][6] = S_M; expst[1][6] = S_I;
        check_all("R12 final");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            lv[c] = 1'b0; lop[c] = 2'(O_NO); lidx[c] = '0;
            bdone[c] = 1'b0; bsh[c] = 1'b0; bdr[c] = 1'b0;
            sv[c] = 1'b0; sop[c] = 2'd0; sidx[c] = '0; ridx[c] = '0;
            for (int i = 0; i < NL; i++) expst[c][i] = S_I;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_paths();
        t_upgrade_and_recent();
        t_hits();
        t_snoop_rfo_evict();
        t_stall();
        t_op_follows_state();
        summary();
        $finish;
    end
endmodule